// File: doc/BRIEF.md
# Hashed Set-Associative Translation Buffer

This block caches virtual-to-physical address mappings whose regions may have any size. Storage is split into buckets chosen by a hash of the virtual page number. Each bucket is a small ring of entries that is filled round-robin. Each entry keeps its virtual base, the XOR of its virtual and physical bases (the shadow word), its region size, a 4-bit domain and a 2-bit access permission. A lookup therefore needs no physical-base field: the physical address is the shadow word XORed with the looked-up virtual address.

An insert port writes one entry per cycle. A probe port starts a lookup that walks one entry of the selected bucket per cycle. The walk begins at the slot most recently written or hit and moves downward through the ring. A one-cycle done strobe carries the result. A flush input empties the whole buffer. Table walking, permission enforcement and memory access belong to the surrounding logic.

Top module: `hashed_tlb`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) leaves every entry invalid and every bucket pointer at slot 0, with prb_done, prb_busy and prb_hit low.
- R2: The bucket of an address v is computed with page shift 12 and 32 buckets. Let h = v >> 12. The bucket is the low 5 bits of h ^ (h >> 6) ^ (h >> 12). Inserts use the bucket of ins_va and probes use the bucket of prb_va, so a probe can only find entries stored in its own bucket.
- R3: An insert writes its entry into the bucket's write slot. The bucket's recent slot is then set to that slot, and the write slot advances by one, wrapping from 7 to 0. A ninth insert into a bucket therefore overwrites the first one.
- R4: An entry matches a probe address v when it is valid, base <= v, and v < base + size. The sum is taken without wrap-around. An entry of size 0 never matches.
- R5: A probe examines the slots of its bucket starting at the recent slot and stepping downward, wrapping from 0 to 7, for at most 8 slots. The first matching entry is returned, so the most recent of two overlapping entries wins.
- R6: On a hit, the bucket's recent slot becomes the slot that hit, which changes where later probes of that bucket start.
- R7: On a hit, prb_hit is 1, prb_pa is the stored shadow word XOR prb_va, and prb_ap and prb_dom are the stored values. On a miss, prb_hit, prb_pa, prb_ap and prb_dom are all 0.
- R8: prb_done is a one-cycle pulse. For a hit found at the n-th examined slot (n = 1..8), it appears n clock edges after the edge that accepts the probe. For a miss, it appears 8 edges after that edge.
- R9: prb_req is accepted only while prb_busy is low. prb_busy is high from acceptance until the result edge. A request made while busy is ignored and produces no result.
- R10: An insert and a probe accepted in the same cycle are ordered insert first, so the probe sees the new entry.
- R11: flush invalidates every entry and returns all pointers to slot 0. It takes priority over an insert in the same cycle, which is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries, reset pointers |
| ins_valid | input | 1 | Insert strobe |
| ins_va | input | 32 | Virtual base of the new entry |
| ins_pa | input | 32 | Physical base of the new entry |
| ins_ap | input | 2 | Access permission of the new entry |
| ins_dom | input | 4 | Domain of the new entry |
| ins_size | input | 32 | Region size in bytes |
| prb_req | input | 1 | Start a lookup (taken when not busy) |
| prb_va | input | 32 | Virtual address to look up |
| prb_busy | output | 1 | Lookup in progress |
| prb_done | output | 1 | One-cycle result strobe |
| prb_hit | output | 1 | Result: a matching entry was found |
| prb_pa | output | 32 | Result: translated physical address |
| prb_ap | output | 2 | Result: access permission |
| prb_dom | output | 4 | Result: domain |

## Verification
The hardest conditions to reach from the ports depend on bucket history. Examples are the ring wrap that evicts the oldest entry and the walk order after a hit has moved the recent slot. Both need many inserts that all land in one bucket. The bench runs the hash forward over many page numbers to collect colliding addresses. It then stacks overlapping entries so that only the correct start slot and direction give the expected entry and latency. The same-cycle insert and probe, the flush that hides an insert, and a request made during a walk are each driven on exact cycles.

// File: rtl/tlb_pkg.sv
// Shared types for the hashed translation buffer.
// Assumes a fixed 32-bit address space; geometry is set per instance.
package tlb_pkg;
    localparam int TLB_AW    = 32;
    localparam int TLB_DOM_W = 4;
    localparam int TLB_AP_W  = 2;

    typedef logic [TLB_AW-1:0] addr_t;

    // Payload of one entry (the valid bit is kept apart so only it is reset)
    typedef struct packed {
        addr_t                 base;
        addr_t                 shadow;
        addr_t                 span;
        logic [TLB_DOM_W-1:0]  dom;
        logic [TLB_AP_W-1:0]   ap;
    } tlb_data_t;

    typedef enum logic {SC_IDLE, SC_SCAN} scan_st_e;
endpackage

// File: rtl/tlb_hash.sv
// Bucket selector: folds the virtual page number onto itself and keeps
// the low bits. Assumes NUM_BKT is a power of two.
module tlb_hash
    import tlb_pkg::*;
#(
    parameter int NUM_BKT  = 32,
    parameter int PG_SHIFT = 12,
    localparam int BKT_W   = $clog2(NUM_BKT)
) (
    input  addr_t             va,
    output logic [BKT_W-1:0]  bkt
);
    addr_t page;
    addr_t mix;

    // Fold page number with two shifted copies of itself
    always_comb begin
        page = va >> PG_SHIFT;
        mix  = page ^ (page >> (PG_SHIFT / 2)) ^ (page >> PG_SHIFT);
        bkt  = mix[BKT_W-1:0];
    end
endmodule

// File: rtl/tlb_range_cmp.sv
// Range test of one entry: base <= va < base + span, with the upper bound
// formed one bit wider so a region ending at the top of memory still works.
module tlb_range_cmp
    import tlb_pkg::*;
(
    input  logic  vld,
    input  addr_t base,
    input  addr_t span,
    input  addr_t va,
    output logic  match
);
    logic [TLB_AW:0] limit;

    // Widened limit and both bound checks
    always_comb begin
        limit = {1'b0, base} + {1'b0, span};
        match = vld && (va >= base) && ({1'b0, va} < limit);
    end
endmodule

// File: rtl/tlb_store.sv
// Entry storage and per-bucket pointers. Holds the valid bits (reset and
// flush clear them), the entry payloads (written only by insert), and for
// each bucket a write slot and a recent slot. Insert beats hit update on the
// same bucket; flush beats both. WAYS must be a power of two.
module tlb_store
    import tlb_pkg::*;
#(
    parameter int NUM_BKT  = 32,
    parameter int WAYS     = 8,
    localparam int BKT_W   = $clog2(NUM_BKT),
    localparam int SLOT_W  = $clog2(WAYS),
    localparam int IDX_W   = BKT_W + SLOT_W,
    localparam int NUM_ENT = NUM_BKT * WAYS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               ins_valid,
    input  logic [BKT_W-1:0]   ins_bkt,
    input  tlb_data_t          ins_data,
    input  logic [BKT_W-1:0]   rd_bkt,
    input  logic [SLOT_W-1:0]  rd_slot,
    output tlb_data_t          rd_data,
    output logic               rd_vld,
    input  logic [BKT_W-1:0]   start_bkt,
    output logic [SLOT_W-1:0]  start_slot,
    input  logic               hit_upd,
    input  logic [BKT_W-1:0]   hit_bkt,
    input  logic [SLOT_W-1:0]  hit_slot
);
    tlb_data_t          data   [NUM_ENT];
    logic [NUM_ENT-1:0] vld;
    logic [SLOT_W-1:0]  wr_ptr [NUM_BKT];
    logic [SLOT_W-1:0]  rd_ptr [NUM_BKT];
    logic               ins_en;
    logic [IDX_W-1:0]   ins_idx;
    logic [IDX_W-1:0]   rd_idx;

    assign ins_en  = ins_valid && !flush;
    assign ins_idx = {ins_bkt, wr_ptr[ins_bkt]};
    assign rd_idx  = {rd_bkt, rd_slot};
    assign rd_data = data[rd_idx];
    assign rd_vld  = vld[rd_idx];

    // Start slot for a new walk; a same-cycle insert into that bucket wins
    assign start_slot = (ins_en && (ins_bkt == start_bkt)) ? wr_ptr[ins_bkt]
                                                           : rd_ptr[start_bkt];

    // Valid bits: cleared by reset or flush, set by insert
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vld <= '0;
        end else if (ins_en) begin
            vld[ins_idx] <= 1'b1;
        end
    end

    // Entry payload write
    always_ff @(posedge clk) begin
        if (ins_en) begin
            data[ins_idx] <= ins_data;
        end
    end

    // Bucket pointers: insert sets recent slot and steps the write slot
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int b = 0; b < NUM_BKT; b++) begin
                wr_ptr[b] <= '0;
                rd_ptr[b] <= '0;
            end
        end else begin
            if (hit_upd && !(ins_en && (ins_bkt == hit_bkt))) begin
                rd_ptr[hit_bkt] <= hit_slot;
            end
            if (ins_en) begin
                rd_ptr[ins_bkt] <= wr_ptr[ins_bkt];
                wr_ptr[ins_bkt] <= wr_ptr[ins_bkt] + SLOT_W'(1);
            end
        end
    end

    AST_INS_SETS_RECENT: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |=> (rd_ptr[$past(ins_bkt)] == $past(wr_ptr[ins_bkt])));  // R3
    AST_INS_STEPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |=> (wr_ptr[$past(ins_bkt)] == $past(wr_ptr[ins_bkt]) + SLOT_W'(1)));  // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld == '0));  // R11
endmodule

// File: rtl/tlb_scan.sv
// Lookup walker: latches the probe address, bucket and start slot, then
// examines one slot per cycle, stepping downward through the ring. It stops
// at the first match or after WAYS slots and raises a one-cycle done with
// the result. Requests made while walking are ignored.
module tlb_scan
    import tlb_pkg::*;
#(
    parameter int NUM_BKT = 32,
    parameter int WAYS    = 8,
    localparam int BKT_W  = $clog2(NUM_BKT),
    localparam int SLOT_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  prb_req,
    input  addr_t                 prb_va,
    input  logic [BKT_W-1:0]      prb_bkt,
    input  logic [SLOT_W-1:0]     start_slot,
    input  tlb_data_t             ent,
    input  logic                  ent_vld,
    output logic [BKT_W-1:0]      cur_bkt,
    output logic [SLOT_W-1:0]     cur_slot,
    output logic                  hit_upd,
    output logic                  busy,
    output logic                  done,
    output logic                  hit,
    output addr_t                 pa,
    output logic [TLB_AP_W-1:0]   ap,
    output logic [TLB_DOM_W-1:0]  dom
);
    scan_st_e          st;
    addr_t             cur_va;
    logic [SLOT_W-1:0] step;
    logic              match;

    tlb_range_cmp u_cmp (
        .vld   (ent_vld),
        .base  (ent.base),
        .span  (ent.span),
        .va    (cur_va),
        .match (match)
    );

    assign busy    = (st == SC_SCAN);
    assign hit_upd = busy && match;

    // Walk state machine and registered result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SC_IDLE;
            cur_va   <= '0;
            cur_bkt  <= '0;
            cur_slot <= '0;
            step     <= '0;
            done     <= 1'b0;
            hit      <= 1'b0;
            pa       <= '0;
            ap       <= '0;
            dom      <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                SC_IDLE: begin
                    if (prb_req) begin
                        st       <= SC_SCAN;
                        cur_va   <= prb_va;
                        cur_bkt  <= prb_bkt;
                        cur_slot <= start_slot;
                        step     <= '0;
                    end
                end
                SC_SCAN: begin
                    if (match) begin
                        st   <= SC_IDLE;
                        done <= 1'b1;
                        hit  <= 1'b1;
                        pa   <= ent.shadow ^ cur_va;
                        ap   <= ent.ap;
                        dom  <= ent.dom;
                    end else if (step == SLOT_W'(WAYS - 1)) begin
                        st   <= SC_IDLE;
                        done <= 1'b1;
                        hit  <= 1'b0;
                        pa   <= '0;
                        ap   <= '0;
                        dom  <= '0;
                    end else begin
                        cur_slot <= cur_slot - SLOT_W'(1);
                        step     <= step + SLOT_W'(1);
                    end
                end
                default: st <= SC_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R8
    AST_HIT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !done) |-> $stable(hit));  // R7
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> (pa == '0 && ap == '0 && dom == '0));  // R7
    AST_REQ_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cur_va));  // R9
endmodule

// File: rtl/hashed_tlb.sv
// Top of the hashed translation buffer: hashes the insert and probe
// addresses into buckets, forms the shadow word, and joins storage to the
// walker. Geometry is parameterised; addresses are 32 bits.
module hashed_tlb
    import tlb_pkg::*;
#(
    parameter int NUM_BKT  = 32,
    parameter int WAYS     = 8,
    parameter int PG_SHIFT = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        ins_valid,
    input  logic [31:0] ins_va,
    input  logic [31:0] ins_pa,
    input  logic [1:0]  ins_ap,
    input  logic [3:0]  ins_dom,
    input  logic [31:0] ins_size,
    input  logic        prb_req,
    input  logic [31:0] prb_va,
    output logic        prb_busy,
    output logic        prb_done,
    output logic        prb_hit,
    output logic [31:0] prb_pa,
    output logic [1:0]  prb_ap,
    output logic [3:0]  prb_dom
);
    localparam int BKT_W  = $clog2(NUM_BKT);
    localparam int SLOT_W = $clog2(WAYS);

    logic [BKT_W-1:0]  ins_bkt, prb_bkt, cur_bkt;
    logic [SLOT_W-1:0] start_slot, cur_slot;
    tlb_data_t         ins_data, rd_data;
    logic              rd_vld, hit_upd;

    // Pack the new entry with its shadow word
    always_comb begin
        ins_data.base   = ins_va;
        ins_data.shadow = ins_va ^ ins_pa;
        ins_data.span   = ins_size;
        ins_data.dom    = ins_dom;
        ins_data.ap     = ins_ap;
    end

    tlb_hash #(.NUM_BKT(NUM_BKT), .PG_SHIFT(PG_SHIFT)) u_hash_ins (
        .va (ins_va), .bkt (ins_bkt)
    );
    tlb_hash #(.NUM_BKT(NUM_BKT), .PG_SHIFT(PG_SHIFT)) u_hash_prb (
        .va (prb_va), .bkt (prb_bkt)
    );

    tlb_store #(.NUM_BKT(NUM_BKT), .WAYS(WAYS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .ins_valid  (ins_valid),
        .ins_bkt    (ins_bkt),
        .ins_data   (ins_data),
        .rd_bkt     (cur_bkt),
        .rd_slot    (cur_slot),
        .rd_data    (rd_data),
        .rd_vld     (rd_vld),
        .start_bkt  (prb_bkt),
        .start_slot (start_slot),
        .hit_upd    (hit_upd),
        .hit_bkt    (cur_bkt),
        .hit_slot   (cur_slot)
    );

    tlb_scan #(.NUM_BKT(NUM_BKT), .WAYS(WAYS)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .prb_req    (prb_req),
        .prb_va     (prb_va),
        .prb_bkt    (prb_bkt),
        .start_slot (start_slot),
        .ent        (rd_data),
        .ent_vld    (rd_vld),
        .cur_bkt    (cur_bkt),
        .cur_slot   (cur_slot),
        .hit_upd    (hit_upd),
        .busy       (prb_busy),
        .done       (prb_done),
        .hit        (prb_hit),
        .pa         (prb_pa),
        .ap         (prb_ap),
        .dom        (prb_dom)
    );
endmodule

// File: tb/test_hashed_tlb.sv
module test_hashed_tlb;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 32;
    localparam int NW = 8;
    localparam int PS = 12;

    logic        clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
    logic        ins_valid = 1'b0;
    logic [31:0] ins_va = '0, ins_pa = '0, ins_size = '0;
    logic [1:0]  ins_ap = '0;
    logic [3:0]  ins_dom = '0;
    logic        prb_req = 1'b0;
    logic [31:0] prb_va = '0;
    logic        prb_busy, prb_done, prb_hit;
    logic [31:0] prb_pa;
    logic [1:0]  prb_ap;
    logic [3:0]  prb_dom;

    hashed_tlb i_hashed_tlb (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_err = 0, cyc = 0, acc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct packed {
        logic        hit;
        logic [31:0] pa;
        logic [1:0]  ap;
        logic [3:0]  dom;
        int          lat;
    } exp_t;
    exp_t  expq[$];
    string tagq[$];

    // Reference model state
    logic [31:0] m_base [NB][NW];
    logic [31:0] m_sh   [NB][NW];
    logic [31:0] m_span [NB][NW];
    logic [1:0]  m_ap   [NB][NW];
    logic [3:0]  m_dom  [NB][NW];
    logic        m_vld  [NB][NW];
    int          m_wr   [NB];
    int          m_rd   [NB];

    function automatic int bkt_of(logic [31:0] va);
        logic [31:0] h;
        h = va >> PS;
        return int'((h ^ (h >> (PS/2)) ^ (h >> PS)) & 32'd31);
    endfunction

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    task automatic m_flush();
        for (int b = 0; b < NB; b++) begin
            m_wr[b] = 0; m_rd[b] = 0;
            for (int s = 0; s < NW; s++) m_vld[b][s] = 1'b0;
        end
    endtask

    task automatic m_insert(input logic [31:0] va, pa, input logic [1:0] ap,
                            input logic [3:0] dom, input logic [31:0] sz);
        int b, s;
        b = bkt_of(va); s = m_wr[b];
        m_base[b][s] = va; m_sh[b][s] = va ^ pa; m_span[b][s] = sz;
        m_ap[b][s] = ap; m_dom[b][s] = dom; m_vld[b][s] = 1'b1;
        m_rd[b] = s; m_wr[b] = (s + 1) % NW;
    endtask

    task automatic m_probe(input logic [31:0] va, output exp_t e);
        int b, i;
        b = bkt_of(va);
        e = '0; e.lat = NW;
        for (int j = 0; j < NW; j++) begin
            i = (m_rd[b] - j + NW) % NW;
            if (m_vld[b][i] && m_base[b][i] <= va &&
                {1'b0, va} < ({1'b0, m_base[b][i]} + {1'b0, m_span[b][i]})) begin
                e.hit = 1'b1; e.pa = m_sh[b][i] ^ va;
                e.ap = m_ap[b][i]; e.dom = m_dom[b][i]; e.lat = j + 1;
                m_rd[b] = i;
                return;
            end
        end
    endtask

    // Monitor: pops expected results as the design reports them
    always @(negedge clk) begin
        if (rst_n && prb_done) begin
            if (expq.size() == 0) begin
                check(1'b0, "R9 unexpected done", "done", "none");
            end else begin
                exp_t  e;
                string t;
                e = expq.pop_front(); t = tagq.pop_front();
                check(prb_hit == e.hit && prb_pa == e.pa && prb_ap == e.ap && prb_dom == e.dom,
                      {t, " R7 result"},
                      $sformatf("hit=%0d pa=%h ap=%0d dom=%0d", prb_hit, prb_pa, prb_ap, prb_dom),
                      $sformatf("hit=%0d pa=%h ap=%0d dom=%0d", e.hit, e.pa, e.ap, e.dom));
                check(cyc - acc == e.lat, {t, " R8 latency"},
                      $sformatf("%0d", cyc - acc), $sformatf("%0d", e.lat));
            end
        end
    end

    task automatic ins(input logic [31:0] va, pa, input logic [1:0] ap,
                       input logic [3:0] dom, input logic [31:0] sz);
        @(negedge clk);
        ins_valid = 1'b1; ins_va = va; ins_pa = pa; ins_ap = ap; ins_dom = dom; ins_size = sz;
        @(negedge clk);
        ins_valid = 1'b0;
        m_insert(va, pa, ap, dom, sz);
    endtask

    task automatic wait_done();
        while (!prb_done) @(negedge clk);
    endtask

    task automatic probe(input logic [31:0] va, input string tag);
        exp_t e;
        m_probe(va, e);
        expq.push_back(e); tagq.push_back(tag);
        @(negedge clk);
        prb_req = 1'b1; prb_va = va;
        @(negedge clk);
        acc = cyc; prb_req = 1'b0;
        wait_done();
    endtask

    task automatic do_flush(input bit with_ins, input logic [31:0] va);
        @(negedge clk);
        flush = 1'b1;
        ins_valid = with_ins; ins_va = va; ins_pa = 32'h5555_0000; ins_size = 32'h1000;
        @(negedge clk);
        flush = 1'b0; ins_valid = 1'b0;
        m_flush();
    endtask

    logic [31:0] col [12];
    logic [31:0] grp [4];

    initial begin : main
        exp_t e;
        int   k;
        m_flush();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!prb_done && !prb_busy && !prb_hit, "R1 reset outputs",
              $sformatf("%b%b%b", prb_done, prb_busy, prb_hit), "000");
        probe(32'h0000_0000, "R1 empty miss");

        // Range boundaries within one page (same bucket)
        ins(32'h0004_5400, 32'h8765_4400, 2'd2, 4'd7, 32'h800);
        probe(32'h0004_5400, "R4 at base");
        probe(32'h0004_5BFF, "R4 last byte");
        probe(32'h0004_5C00, "R4 end excluded");
        probe(32'h0004_53FF, "R4 below base");
        ins(32'h0007_7000, 32'h1111_1000, 2'd1, 4'd1, 32'h0);
        probe(32'h0007_7000, "R4 size zero");
        ins(32'hFFFF_F000, 32'h0000_3000, 2'd3, 4'd15, 32'h1000);
        probe(32'hFFFF_FFFF, "R4 top of memory");

        // Large region: only probes hashing to its bucket find it
        ins(32'h0010_0000, 32'h0230_0000, 2'd3, 4'd5, 32'h0010_0000);
        probe(32'h0010_0123, "R7 shadow pa");
        k = bkt_of(32'h0010_0000);
        for (int h = 32'h101; h < 32'h200; h++) begin
            if (bkt_of(h << PS) != k) begin
                probe(h << PS, "R2 other bucket");
                break;
            end
        end

        // Collect addresses colliding in bucket 3
        k = 0;
        for (int h = 1; h < 32'h10000 && k < 12; h++)
            if (bkt_of(h << PS) == 3) begin col[k] = h << PS; k++; end
        for (int i = 0; i < 9; i++)
            ins(col[i], 32'h4000_0000 + (i << PS), 2'(i), 4'(i), 32'h1000);
        probe(col[0], "R3 wrap evicts oldest");
        probe(col[8] + 32'h10, "R3 newest first");
        probe(col[1] + 32'h20, "R5 downward wrap");

        // Walk order and recent-slot update in bucket 9
        k = 0;
        for (int h = 1; h < 32'h10000 && k < 4; h++)
            if (bkt_of(h << PS) == 9) begin grp[k] = h << PS; k++; end
        ins(grp[0], 32'h1000_0000, 2'd0, 4'd2, 32'h1000);
        ins(grp[0] + 32'h800, 32'h2000_0800, 2'd1, 4'd3, 32'h800);
        ins(grp[1], 32'h3000_0000, 2'd2, 4'd4, 32'h1000);
        probe(grp[0] + 32'h10, "R5 third slot");
        probe(grp[0] + 32'h900, "R6 start at hit slot");
        ins(grp[0], 32'h6000_0000, 2'd3, 4'd6, 32'h1000);
        probe(grp[0] + 32'h4, "R5 overlap newest wins");

        // Insert and probe in the same cycle
        m_insert(grp[2], 32'h7700_0000, 2'd1, 4'd9, 32'h1000);
        m_probe(grp[2] + 32'h44, e);
        expq.push_back(e); tagq.push_back("R10 same cycle");
        @(negedge clk);
        ins_valid = 1'b1; ins_va = grp[2]; ins_pa = 32'h7700_0000; ins_ap = 2'd1;
        ins_dom = 4'd9; ins_size = 32'h1000; prb_req = 1'b1; prb_va = grp[2] + 32'h44;
        @(negedge clk);
        acc = cyc; ins_valid = 1'b0; prb_req = 1'b0;
        wait_done();

        // Request during a walk is ignored
        m_probe(32'h0ABC_D000, e);
        expq.push_back(e); tagq.push_back("R9 first request");
        @(negedge clk);
        prb_req = 1'b1; prb_va = 32'h0ABC_D000;
        @(negedge clk);
        acc = cyc; prb_req = 1'b0;
        @(negedge clk);
        check(prb_busy, "R9 busy during walk", $sformatf("%b", prb_busy), "1");
        prb_req = 1'b1; prb_va = grp[2];
        @(negedge clk);
        prb_req = 1'b0;
        wait_done();
        repeat (12) @(negedge clk);
        check(expq.size() == 0 && !prb_busy, "R9 no extra result",
              $sformatf("%0d", expq.size()), "0");

        // Flush
        do_flush(1'b0, '0);
        probe(grp[0] + 32'h4, "R11 flushed miss");
        probe(32'h0004_5400, "R11 flushed miss 2");
        do_flush(1'b1, col[2]);
        probe(col[2], "R11 insert dropped");
        ins(col[3], 32'h0BAD_0000, 2'd2, 4'd12, 32'h1000);
        probe(col[3] + 32'h8, "R11 refill after flush");

        // Reset mid-state clears contents
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_flush();
        probe(col[3] + 32'h8, "R1 reset clears");

        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R8 all results seen", $sformatf("%0d", expq.size()), "0");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule